// File: doc/BRIEF.md
# Flag-Setting Data-Processing ALU

This block is the arithmetic and logic stage of a 32-bit integer datapath. Each cycle that `valid_i` is high it takes an opcode, two operands, an incoming carry and the carry produced by the operand shifter. At the next clock edge it registers a result and the next condition flags: negative, zero, carry and overflow. There are sixteen opcodes. Six are bitwise operations and six are arithmetic operations with forward, reverse and carry-chained forms. The last four are compare/test operations. They update the flags and write no result.

The flags are held in registers. They change only when the caller asks for it through `set_flags_i`, or when the opcode is a compare/test. A later condition check therefore sees the flags of the last operation that set them. The operand shifter, the register file and the condition evaluation sit outside this block.

Top module: `dp_alu`

## Requirements
- R1: While `rst_ni` is low, `res_o`, `res_vld_o` and `flags_o` are all zero.
- R2: `op_i` codes 0, 1, 12, 13, 14 and 15 select the bitwise operations. Their results are a AND b, a XOR b, a OR b, b, a AND NOT b, and NOT b.
- R3: Codes 2, 3 and 4 compute a−b, b−a and a+b. For an add, C is the carry out of bit 31. For a subtract, C is 1 when no borrow occurs (minuend ≥ subtrahend, unsigned).
- R4: Codes 5, 6 and 7 use `carry_i`. They compute a+b+carry_i, a−b−(1−carry_i) and b−a−(1−carry_i), and C follows the same rules as in R3.
- R5: Codes 8, 9, 10 and 11 are compares. They compute AND, XOR, subtract and add and always update the flags. They leave `res_vld_o` low and `res_o` unchanged.
- R6: When the flags update, N takes bit 31 of the computed value. Z is 1 exactly when that value is zero.
- R7: When an arithmetic opcode updates the flags, V is 1 exactly when the operation overflows as a signed operation.
- R8: When a bitwise opcode updates the flags, C takes `shift_carry_i` and V keeps its previous value.
- R9: `flags_o` stays unchanged in a cycle where `valid_i` is low. It also stays unchanged when `set_flags_i` is low and the opcode is not a compare.
- R10: The result and flags appear one clock after the operation is presented. `res_vld_o` is high for one cycle for each accepted non-compare operation, and is low after a cycle with `valid_i` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Operation present this cycle |
| op_i | input | 4 | Opcode (encoding in R2–R5) |
| a_i | input | 32 | First operand |
| b_i | input | 32 | Second operand, already shifted |
| carry_i | input | 1 | Carry input for the carry-chained opcodes |
| shift_carry_i | input | 1 | Carry produced by the operand shifter |
| set_flags_i | input | 1 | Request to update the flags |
| res_o | output | 32 | Registered result |
| res_vld_o | output | 1 | Result written this cycle |
| flags_o | output | 4 | Registered flags {N, Z, C, V} |

## Verification
Two functions can fall in the same cycle. One is updating the flags; the other is leaving part of the state alone. A compare must refresh the flags while `res_o` keeps the last written value and `res_vld_o` stays low. A flag-setting bitwise opcode must take C from the shifter and keep V, which only an earlier arithmetic operation can have set. The vector table orders these cases on purpose: an overflowing add is placed right before a bitwise operation, and a compare right after a written result. Each cycle's result, valid bit and all four flags are judged against values worked out by hand.

// File: rtl/dp_alu_pkg.sv
package dp_alu_pkg;
  typedef enum logic [3:0] {
    OP_AND = 4'd0,  OP_EOR = 4'd1,  OP_SUB = 4'd2,  OP_RSB = 4'd3,
    OP_ADD = 4'd4,  OP_ADC = 4'd5,  OP_SBC = 4'd6,  OP_RSC = 4'd7,
    OP_TST = 4'd8,  OP_TEQ = 4'd9,  OP_CMP = 4'd10, OP_CMN = 4'd11,
    OP_ORR = 4'd12, OP_MOV = 4'd13, OP_BIC = 4'd14, OP_MVN = 4'd15
  } alu_op_e;

  typedef struct packed {
    logic n;
    logic z;
    logic c;
    logic v;
  } alu_flags_t;

  function automatic logic op_is_cmp(input logic [3:0] op);
    return op[3:2] == 2'b10;
  endfunction

  function automatic logic op_is_arith(input logic [3:0] op);
    return (op >= 4'd2 && op <= 4'd7) || op == 4'd10 || op == 4'd11;
  endfunction
endpackage

// File: rtl/dp_alu_logic.sv
module dp_alu_logic
  import dp_alu_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [3:0]   op_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] y_o
);
  always_comb begin
    unique case (alu_op_e'(op_i))
      OP_AND, OP_TST: y_o = a_i & b_i;
      OP_EOR, OP_TEQ: y_o = a_i ^ b_i;
      OP_ORR:         y_o = a_i | b_i;
      OP_MOV:         y_o = b_i;
      OP_BIC:         y_o = a_i & ~b_i;
      OP_MVN:         y_o = ~b_i;
      default:        y_o = '0;
    endcase
  end
endmodule

// File: rtl/dp_alu_adder.sv
module dp_alu_adder
  import dp_alu_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [3:0]   op_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         carry_i,
  output logic [W-1:0] sum_o,
  output logic         cout_o,
  output logic         ovf_o
);
  logic [W-1:0] x, y;
  logic         cin;
  logic [W:0]   full;

  // subtraction as x + ~y + 1; carry out then means "no borrow"
  always_comb begin
    unique case (alu_op_e'(op_i))
      OP_SUB, OP_CMP: begin x = a_i; y = ~b_i; cin = 1'b1;    end
      OP_RSB:         begin x = b_i; y = ~a_i; cin = 1'b1;    end
      OP_ADC:         begin x = a_i; y = b_i;  cin = carry_i; end
      OP_SBC:         begin x = a_i; y = ~b_i; cin = carry_i; end
      OP_RSC:         begin x = b_i; y = ~a_i; cin = carry_i; end
      default:        begin x = a_i; y = b_i;  cin = 1'b0;    end
    endcase
  end

  assign full   = {1'b0, x} + {1'b0, y} + {{W{1'b0}}, cin};
  assign sum_o  = full[W-1:0];
  assign cout_o = full[W];
  assign ovf_o  = (x[W-1] == y[W-1]) && (full[W-1] != x[W-1]);
endmodule

// File: rtl/dp_alu.sv
module dp_alu
  import dp_alu_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         valid_i,
  input  logic [3:0]   op_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         carry_i,
  input  logic         shift_carry_i,
  input  logic         set_flags_i,
  output logic [W-1:0] res_o,
  output logic         res_vld_o,
  output logic [3:0]   flags_o
);
  logic [W-1:0] log_y, add_y, nxt_res;
  logic         add_c, add_v, arith, cmp;
  alu_flags_t   flags_q, nxt_flags;
  logic [W-1:0] res_q;
  logic         vld_q;

  dp_alu_logic #(.W(W)) u_logic (
    .op_i(op_i), .a_i(a_i), .b_i(b_i), .y_o(log_y)
  );

  dp_alu_adder #(.W(W)) u_adder (
    .op_i(op_i), .a_i(a_i), .b_i(b_i), .carry_i(carry_i),
    .sum_o(add_y), .cout_o(add_c), .ovf_o(add_v)
  );

  assign arith   = op_is_arith(op_i);
  assign cmp     = op_is_cmp(op_i);
  assign nxt_res = arith ? add_y : log_y;

  always_comb begin
    nxt_flags.n = nxt_res[W-1];
    nxt_flags.z = (nxt_res == '0);
    nxt_flags.c = arith ? add_c : shift_carry_i;
    nxt_flags.v = arith ? add_v : flags_q.v;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_q   <= '0;
      vld_q   <= 1'b0;
      flags_q <= '0;
    end else begin
      vld_q <= valid_i && !cmp;
      if (valid_i && !cmp)                 res_q   <= nxt_res;
      if (valid_i && (set_flags_i || cmp)) flags_q <= nxt_flags;
    end
  end

  assign res_o     = res_q;
  assign res_vld_o = vld_q;
  assign flags_o   = flags_q;
endmodule

// File: rtl/dp_alu_chk.sv
module dp_alu_chk
  import dp_alu_pkg::*;
#(
  parameter int W = 32
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         valid_i,
  input logic [3:0]   op_i,
  input logic         shift_carry_i,
  input logic         set_flags_i,
  input logic [W-1:0] res_o,
  input logic         res_vld_o,
  input logic [3:0]   flags_o
);
  p_cmp_nowb_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && op_is_cmp(op_i) |=> !res_vld_o && $stable(res_o));

  p_nz_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && set_flags_i && !op_is_cmp(op_i)
    |=> flags_o[3] == res_o[W-1] && flags_o[2] == (res_o == '0));

  p_logic_cv_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && (set_flags_i || op_is_cmp(op_i)) && !op_is_arith(op_i)
    |=> flags_o[1] == $past(shift_carry_i) && $stable(flags_o[0]));

  p_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i || (!set_flags_i && !op_is_cmp(op_i)) |=> $stable(flags_o));

  p_vld_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && !op_is_cmp(op_i) |=> res_vld_o);

  p_idle_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !res_vld_o && $stable(res_o));
endmodule

bind dp_alu dp_alu_chk #(.W(W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i), .op_i(op_i),
  .shift_carry_i(shift_carry_i), .set_flags_i(set_flags_i),
  .res_o(res_o), .res_vld_o(res_vld_o), .flags_o(flags_o)
);

// File: tb/dp_alu_tb_top.sv
module dp_alu_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 18;

  typedef struct packed {
    logic [3:0]  op;
    logic [31:0] a;
    logic [31:0] b;
    logic        cin;
    logic        shc;
    logic        s;
    logic [31:0] res;
    logic        vld;
    logic [3:0]  flg;
  } vec_t;

  // flags {N,Z,C,V}; expected values depend on the order (V carried over)
  localparam vec_t VEC [NVEC] = '{
    '{4'd4,  32'h7fffffff, 32'h1,        1'b0, 1'b0, 1'b1, 32'h80000000, 1'b1, 4'b1001},
    '{4'd0,  32'hf0f0f0f0, 32'h0f0f0f0f, 1'b0, 1'b1, 1'b1, 32'h0,        1'b1, 4'b0111},
    '{4'd2,  32'h5,        32'h5,        1'b0, 1'b0, 1'b1, 32'h0,        1'b1, 4'b0110},
    '{4'd2,  32'h3,        32'h5,        1'b0, 1'b0, 1'b1, 32'hfffffffe, 1'b1, 4'b1000},
    '{4'd3,  32'h3,        32'h5,        1'b0, 1'b0, 1'b1, 32'h2,        1'b1, 4'b0010},
    '{4'd5,  32'hffffffff, 32'h0,        1'b1, 1'b0, 1'b1, 32'h0,        1'b1, 4'b0110},
    '{4'd6,  32'h10,       32'h3,        1'b0, 1'b0, 1'b1, 32'hc,        1'b1, 4'b0010},
    '{4'd7,  32'h3,        32'h10,       1'b1, 1'b0, 1'b1, 32'hd,        1'b1, 4'b0010},
    '{4'd1,  32'hff,       32'h0f,       1'b0, 1'b0, 1'b0, 32'hf0,       1'b1, 4'b0010},
    '{4'd10, 32'h80000000, 32'h1,        1'b0, 1'b0, 1'b0, 32'hf0,       1'b0, 4'b0011},
    '{4'd8,  32'h1,        32'h2,        1'b0, 1'b0, 1'b0, 32'hf0,       1'b0, 4'b0101},
    '{4'd11, 32'hffffffff, 32'h1,        1'b0, 1'b0, 1'b0, 32'hf0,       1'b0, 4'b0110},
    '{4'd9,  32'h80000000, 32'h0,        1'b0, 1'b1, 1'b0, 32'hf0,       1'b0, 4'b1010},
    '{4'd12, 32'h1,        32'h2,        1'b0, 1'b0, 1'b1, 32'h3,        1'b1, 4'b0000},
    '{4'd13, 32'h1234,     32'h0,        1'b0, 1'b1, 1'b1, 32'h0,        1'b1, 4'b0110},
    '{4'd14, 32'hff,       32'h0f,       1'b0, 1'b0, 1'b0, 32'hf0,       1'b1, 4'b0110},
    '{4'd15, 32'h0,        32'h0,        1'b0, 1'b0, 1'b1, 32'hffffffff, 1'b1, 4'b1000},
    '{4'd4,  32'h80000000, 32'h80000000, 1'b0, 1'b0, 1'b1, 32'h0,        1'b1, 4'b0111}
  };

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic [3:0]  op_i = '0;
  logic [31:0] a_i = '0, b_i = '0;
  logic        carry_i = 1'b0, shift_carry_i = 1'b0, set_flags_i = 1'b0;
  logic [31:0] res_o;
  logic        res_vld_o;
  logic [3:0]  flags_o;

  int n_chk = 0;
  int n_err = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  dp_alu dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i), .op_i(op_i),
    .a_i(a_i), .b_i(b_i), .carry_i(carry_i), .shift_carry_i(shift_carry_i),
    .set_flags_i(set_flags_i), .res_o(res_o), .res_vld_o(res_vld_o),
    .flags_o(flags_o)
  );

  task automatic check(input string req, input int idx,
                       input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_err++;
      $display("FAIL %s step %0d: got %h exp %h", req, idx, got, exp);
    end
  endtask

  function automatic string res_req(input logic [3:0] op);
    if (op >= 4'd8 && op <= 4'd11) return "R5";
    if (op >= 4'd5 && op <= 4'd7)  return "R4";
    if (op >= 4'd2 && op <= 4'd4)  return "R3";
    return "R2";
  endfunction

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 2000);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: got timeout exp completion");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    // R1 reset state
    check("R1 res", 0, res_o, 32'h0);
    check("R1 vld", 0, {31'b0, res_vld_o}, 32'h0);
    check("R1 flags", 0, {28'b0, flags_o}, 32'h0);
    rst_ni = 1'b1;
    @(negedge clk_i);

    for (int i = 0; i < NVEC; i++) begin
      valid_i = 1'b1; op_i = VEC[i].op; a_i = VEC[i].a; b_i = VEC[i].b;
      carry_i = VEC[i].cin; shift_carry_i = VEC[i].shc; set_flags_i = VEC[i].s;
      @(negedge clk_i);
      check(res_req(VEC[i].op), i, res_o, VEC[i].res);
      check("R10 R5 vld", i, {31'b0, res_vld_o}, {31'b0, VEC[i].vld});
      check("R6 R7 R8 R9 flags", i, {28'b0, flags_o}, {28'b0, VEC[i].flg});
    end

    // R10 / R9: idle cycle with a flag-setting compare on the pins
    valid_i = 1'b0; op_i = 4'd10; a_i = 32'h0; b_i = 32'h1; set_flags_i = 1'b1;
    @(negedge clk_i);
    check("R10 idle vld", 100, {31'b0, res_vld_o}, 32'h0);
    check("R10 idle res", 100, res_o, 32'h0);
    check("R9 idle flags", 100, {28'b0, flags_o}, 32'h7);

    // R7: subtract overflow, positive minus negative
    valid_i = 1'b1; op_i = 4'd2; a_i = 32'h7fffffff; b_i = 32'hffffffff;
    set_flags_i = 1'b1; carry_i = 1'b0;
    @(negedge clk_i);
    check("R7 res", 101, res_o, 32'h80000000);
    check("R7 flags", 101, {28'b0, flags_o}, 32'h9);

    // R4: SBC with carry set behaves as plain subtract
    op_i = 4'd6; a_i = 32'h10; b_i = 32'h3; carry_i = 1'b1;
    @(negedge clk_i);
    check("R4 sbc", 102, res_o, 32'hd);

    // R1: asynchronous reset mid-run
    valid_i = 1'b0;
    #1 rst_ni = 1'b0;
    #1;
    check("R1 async res", 103, res_o, 32'h0);
    check("R1 async flags", 103, {28'b0, flags_o}, 32'h0);

    done = 1'b1;
    finish_run();
  end
endmodule